// File: doc/BRIEF.md
# Timestamped Write-Capture Trace Probe

This block is a hardware monitor placed beside one processor, and each processor in a system gets its own copy. It watches that processor's store traffic. When software writes to any word inside a small reserved address window, the probe saves a record with three fields: the written data word, the word's position inside the window, and the value of a free-running time counter. The record goes into a local trace FIFO.

Instrumentation code marks events by storing to these reserved words, and the position inside the window tells different event kinds apart. The time counter is 48 bits wide. It advances once every `TICK_DIV` clock cycles, so one count is a fixed real-time step. A host drains the FIFO through a valid/ready port, and the oldest record is always presented first. If an event arrives while the FIFO is full, the event is lost and a sticky flag reports the loss.

Top module: `wtrace_probe`

## Requirements
- R1: After reset, `rd_valid` is 0, `overflow` is 0, and the time counter is 0.
- R2: A record is captured only when `bus_wr_en` is 1 and `bus_addr` lies in [`WIN_BASE`, `WIN_BASE`+`WIN_WORDS`). Cycles with `bus_wr_en` at 0, and writes outside that range, leave the FIFO unchanged.
- R3: A captured record presents the written word on `rd_data` and `bus_addr`−`WIN_BASE` on `rd_offset`.
- R4: `rd_stamp` holds the counter value in the capture cycle. The counter is 0 after reset and increases by one after every `TICK_DIV` clock edges, so N edges after reset it equals floor(N/`TICK_DIV`).
- R5: When `ts_clear` is high at an edge, the counter and its tick divider both return to 0 at that edge, and counting then restarts as in R4.
- R6: The counter is `TS_W` bits wide and wraps from all ones to zero without any indication.
- R7: A record becomes visible on the read port in the cycle after its capture edge. Records leave in capture order, and an accepted read (`rd_valid` and `rd_ready` both high) removes the oldest record.
- R8: A capture that arrives while `DEPTH` records are held, with no read in the same cycle, is dropped and sets `overflow`. `overflow` stays set until `ovf_clear`, and when a drop and `ovf_clear` fall in the same cycle, the set wins.
- R9: When the FIFO is full, a capture and an accepted read in the same cycle both take effect, and no overflow is flagged.
- R10: While `rd_valid` is high and `rd_ready` is low, the presented record holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Processor store strobe |
| bus_addr | input | ADDR_W | Store word address |
| bus_wdata | input | DATA_W | Store data |
| ts_clear | input | 1 | Zero the time counter |
| ovf_clear | input | 1 | Clear the overflow flag |
| rd_valid | output | 1 | A record is presented |
| rd_ready | input | 1 | Host takes the presented record |
| rd_data | output | DATA_W | Captured data word |
| rd_offset | output | OFF_W | Word offset inside the window |
| rd_stamp | output | TS_W | Time counter value at capture |
| overflow | output | 1 | Sticky lost-event flag |

## Verification
The vector table drives stores to both ends of the window, to the words just outside each end, to an address that shares the window's low bits but has different high bits, and a non-write cycle aimed inside the window. Together these separate a correct range compare from an off-by-one bound, a compare on the low bits only, and a decode that ignores the strobe. Back-to-back fills separate correct ordering from reversed ordering. Three cases are then kept apart: a full FIFO with no read (the event is dropped), a full FIFO with a read in the same cycle (the event is accepted), and a drop that coincides with a clear (the flag stays set). A second instance with a 4-bit counter reaches the wrap point, which shows the counter returns to zero rather than saturating.

// File: rtl/wtrace_pkg.sv
package wtrace_pkg;

    // Width of an index into n slots, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // True when n is a nonzero power of two.
    function automatic bit is_pow2(input longint unsigned n);
        return (n != 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/wtrace_tstamp.sv
module wtrace_tstamp
    import wtrace_pkg::*;
#(
    parameter int unsigned TS_W     = 48,
    parameter int unsigned TICK_DIV = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    output logic [TS_W-1:0] stamp_o
);
    localparam int unsigned PS_W = idx_width(TICK_DIV);
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [PS_W-1:0] pre;
        logic [TS_W-1:0] stamp;
    } ts_state_t;

    ts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (st_q.pre == PS_LAST) begin
            st_d.pre   = '0;
            st_d.stamp = st_q.stamp + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp_o = st_q.stamp;

    // R5
    ts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> stamp_o == '0);

    // R4
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && stamp_o != '1 |=> (stamp_o == $past(stamp_o)) ||
                                    (stamp_o == TS_W'($past(stamp_o) + 1'b1)));

    // R6
    ts_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && stamp_o == '1 |=> stamp_o == '1 || stamp_o == '0);

endmodule

// File: rtl/wtrace_match.sv
module wtrace_match
    import wtrace_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0004_0000,
    parameter int unsigned WIN_WORDS = 16,
    parameter int unsigned OFF_W     = 4
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [OFF_W-1:0]  off_o
);
    localparam bit ALIGNED = is_pow2(WIN_WORDS) && ((WIN_BASE % WIN_WORDS) == 0)
                             && (OFF_W < ADDR_W);

    logic [ADDR_W-1:0] delta;
    assign delta = addr_i - WIN_BASE;
    assign off_o = delta[OFF_W-1:0];

    generate
        if (ALIGNED) begin : g_aligned
            // Aligned power-of-two window: compare the upper address bits only.
            assign hit_o = wr_i && (addr_i[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]);
        end else begin : g_range
            assign hit_o = wr_i && (addr_i >= WIN_BASE) && (delta < ADDR_W'(WIN_WORDS));
        end
    endgenerate

endmodule

// File: rtl/wtrace_fifo.sv
module wtrace_fifo
    import wtrace_pkg::*;
#(
    parameter int unsigned REC_W = 84,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [REC_W-1:0] rec_i,
    input  logic             pop_i,
    input  logic             ovf_clr_i,
    output logic [REC_W-1:0] rec_o,
    output logic             valid_o,
    output logic             ovf_o
);
    localparam int unsigned AW = idx_width(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][REC_W-1:0] mem;
        logic [AW:0]                 wp;
        logic [AW:0]                 rp;
        logic                        ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic full, empty, accept, take, drop;
    logic [AW:0] level;

    assign empty = (st_q.wp == st_q.rp);
    assign full  = (st_q.wp[AW] != st_q.rp[AW]) &&
                   (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
    assign take   = pop_i && !empty;
    assign accept = push_i && (!full || take);
    assign drop   = push_i && full && !take;
    assign level  = st_q.wp - st_q.rp;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.mem[st_q.wp[AW-1:0]] = rec_i;
            st_d.wp = st_q.wp + 1'b1;
        end
        if (take) begin
            st_d.rp = st_q.rp + 1'b1;
        end
        st_d.ovf = drop || (st_q.ovf && !ovf_clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_o   = st_q.mem[st_q.rp[AW-1:0]];
    assign valid_o = !empty;
    assign ovf_o   = st_q.ovf;

    // R8
    fifo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !ovf_clr_i |=> ovf_o);

    // R9
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && push_i && pop_i && !ovf_o |=> !ovf_o && valid_o);

endmodule

// File: rtl/wtrace_probe.sv
module wtrace_probe
    import wtrace_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned TS_W      = 48,
    parameter int unsigned TICK_DIV  = 5,
    parameter int unsigned DEPTH     = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0004_0000,
    parameter int unsigned WIN_WORDS = 16,
    parameter int unsigned OFF_W     = idx_width(WIN_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ts_clear,
    input  logic              ovf_clear,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic [OFF_W-1:0]  rd_offset,
    output logic [TS_W-1:0]   rd_stamp,
    output logic              overflow
);
    localparam int unsigned REC_W = TS_W + OFF_W + DATA_W;

    logic              hit;
    logic [OFF_W-1:0]  hit_off;
    logic [TS_W-1:0]   stamp;
    logic [REC_W-1:0]  rec_in, rec_out;

    wtrace_tstamp #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_ts (
        .clk(clk), .rst_n(rst_n), .clr_i(ts_clear), .stamp_o(stamp)
    );

    wtrace_match #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
                   .WIN_WORDS(WIN_WORDS), .OFF_W(OFF_W)) u_match (
        .wr_i(bus_wr_en), .addr_i(bus_addr), .hit_o(hit), .off_o(hit_off)
    );

    assign rec_in = {stamp, hit_off, bus_wdata};

    wtrace_fifo #(.REC_W(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(hit), .rec_i(rec_in),
        .pop_i(rd_valid && rd_ready), .ovf_clr_i(ovf_clear),
        .rec_o(rec_out), .valid_o(rd_valid), .ovf_o(overflow)
    );

    assign rd_data   = rec_out[DATA_W-1:0];
    assign rd_offset = rec_out[DATA_W +: OFF_W];
    assign rd_stamp  = rec_out[DATA_W+OFF_W +: TS_W];

    // R2
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en && !rd_valid |=> !rd_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) &&
                                  $stable(rd_offset) && $stable(rd_stamp));

    // R7
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> $past(rd_ready));

endmodule

// File: tb/sim_wtrace_probe.sv
module sim_wtrace_probe;
    localparam int unsigned ADDR_W = 32, DATA_W = 32, TS_W = 48, TICK_DIV = 5;
    localparam int unsigned DEPTH = 8, WIN_WORDS = 16, OFF_W = 4;
    localparam logic [31:0] BASE = 32'h0004_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_en = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic ts_clear = 1'b0, ovf_clear = 1'b0, rd_ready = 1'b0;
    logic rd_valid, overflow;
    logic [31:0] rd_data;
    logic [3:0]  rd_offset;
    logic [47:0] rd_stamp;

    logic w1_en = 1'b0;
    logic v1, o1;
    logic [31:0] d1;
    logic [3:0]  f1, s1;

    int total = 0, bad = 0;
    bit done = 0;
    logic [63:0] bcnt = '0, bcnt1 = '0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n || ts_clear) bcnt <= '0; else bcnt <= bcnt + 1;
        if (!rst_n) bcnt1 <= '0; else bcnt1 <= bcnt1 + 1;
    end

    wtrace_probe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W), .TICK_DIV(TICK_DIV),
                   .DEPTH(DEPTH), .WIN_BASE(BASE), .WIN_WORDS(WIN_WORDS), .OFF_W(OFF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ts_clear(ts_clear), .ovf_clear(ovf_clear),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_offset(rd_offset), .rd_stamp(rd_stamp), .overflow(overflow)
    );

    wtrace_probe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(4), .TICK_DIV(2),
                   .DEPTH(2), .WIN_BASE(BASE), .WIN_WORDS(WIN_WORDS), .OFF_W(OFF_W)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(w1_en), .bus_addr(BASE),
        .bus_wdata(32'h5A5A_0001), .ts_clear(1'b0), .ovf_clear(1'b0),
        .rd_valid(v1), .rd_ready(1'b0), .rd_data(d1),
        .rd_offset(f1), .rd_stamp(s1), .overflow(o1)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr1(input logic [31:0] a, input logic [31:0] d, output logic [63:0] st);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        st = bcnt / TICK_DIV;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk); rd_ready = 1'b1;
        @(negedge clk); rd_ready = 1'b0;
    endtask

    // {write enable, expect capture, address, data}
    localparam logic [65:0] VEC [0:7] = '{
        {1'b1, 1'b1, BASE,               32'hA000_0001},
        {1'b1, 1'b1, BASE + 32'd15,      32'hA000_0002},
        {1'b1, 1'b0, BASE + 32'd16,      32'hA000_0003},
        {1'b1, 1'b0, BASE - 32'd1,       32'hA000_0004},
        {1'b0, 1'b0, BASE + 32'd3,       32'hA000_0005},
        {1'b1, 1'b1, BASE + 32'd7,       32'hA000_0006},
        {1'b1, 1'b0, 32'h0000_0000,      32'hA000_0007},
        {1'b1, 1'b0, 32'h0014_0003,      32'hA000_0008}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] st;
        logic [63:0] sts [0:DEPTH-1];
        logic [31:0] d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!rd_valid, "R1 rd_valid", rd_valid, 0);
        chk(!overflow, "R1 overflow", overflow, 0);

        // R2/R3/R4 vector table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_wr_en = VEC[i][65]; bus_addr = VEC[i][63:32]; bus_wdata = VEC[i][31:0];
            st = bcnt / TICK_DIV;
            @(negedge clk);
            bus_wr_en = 1'b0;
            chk(rd_valid == VEC[i][64], "R2 capture", rd_valid, VEC[i][64]);
            if (VEC[i][64] && rd_valid) begin
                chk(rd_data == VEC[i][31:0], "R3 data", rd_data, VEC[i][31:0]);
                chk(rd_offset == 4'(VEC[i][63:32] - BASE), "R3 offset", rd_offset,
                    4'(VEC[i][63:32] - BASE));
                chk(rd_stamp == st[47:0], "R4 stamp", rd_stamp, st);
                pop1();
                chk(!rd_valid, "R7 drained", rd_valid, 0);
            end
            repeat (i + 2) @(negedge clk);
        end

        // R5 clear then capture
        @(negedge clk); ts_clear = 1'b1;
        @(negedge clk); ts_clear = 1'b0;
        wr1(BASE + 2, 32'hC1, st);
        chk(rd_stamp == 48'd0 && st == 0, "R5 stamp after clear", rd_stamp, 0);
        pop1();
        repeat (11) @(negedge clk);
        wr1(BASE + 2, 32'hC2, st);
        chk(rd_stamp == st[47:0], "R5 restart count", rd_stamp, st);
        pop1();

        // R7/R10/R8 fill, stall, drop, drain
        for (int i = 0; i < DEPTH; i++) wr1(BASE + 32'(i), 32'h100 + 32'(i), sts[i]);
        chk(!overflow, "R8 no overflow when exactly full", overflow, 0);
        d0 = rd_data;
        repeat (3) @(negedge clk);
        chk(rd_valid && rd_data == d0 && d0 == 32'h100, "R10 held record", rd_data, 32'h100);
        wr1(BASE + 9, 32'hDEAD, st);
        chk(overflow, "R8 drop flags overflow", overflow, 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk(rd_data == 32'h100 + 32'(i), "R7 order", rd_data, 32'h100 + 32'(i));
            chk(rd_stamp == sts[i][47:0], "R4 stamp in burst", rd_stamp, sts[i]);
            pop1();
        end
        chk(!rd_valid, "R8 dropped record absent", rd_valid, 0);
        chk(overflow, "R8 sticky", overflow, 1);
        @(negedge clk); ovf_clear = 1'b1;
        @(negedge clk); ovf_clear = 1'b0;
        chk(!overflow, "R8 clear", overflow, 0);

        // R9 full with simultaneous read
        for (int i = 0; i < DEPTH; i++) wr1(BASE + 1, 32'h200 + 32'(i), st);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = BASE + 4; bus_wdata = 32'h2AA; rd_ready = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; rd_ready = 1'b0;
        chk(!overflow, "R9 no overflow", overflow, 0);
        for (int i = 1; i <= DEPTH; i++) begin
            d0 = (i == DEPTH) ? 32'h2AA : 32'h200 + 32'(i);
            chk(rd_data == d0, "R9 contents", rd_data, d0);
            pop1();
        end
        chk(!rd_valid, "R9 empty", rd_valid, 0);

        // R8 set wins over clear
        for (int i = 0; i < DEPTH; i++) wr1(BASE, 32'h300 + 32'(i), st);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = BASE; bus_wdata = 32'h3FF; ovf_clear = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; ovf_clear = 1'b0;
        chk(overflow, "R8 set beats clear", overflow, 1);

        // R6 wrap on narrow counter instance
        repeat (45) @(negedge clk);
        @(negedge clk);
        w1_en = 1'b1;
        st = (bcnt1 / 2) % 16;
        @(negedge clk);
        w1_en = 1'b0;
        chk(v1 && s1 == st[3:0] && bcnt1 > 34, "R6 wrapped stamp", s1, st);

        finish_run();
    end
endmodule